// File: doc/BRIEF.md
# Gradient Flood Spanning-Tree Node

This block is the configuration-time logic of one node in a mesh, where every node has four bidirectional links. During configuration, roots flood gradient packets through the mesh. Every node keeps the link on which the first copy of a gradient arrived as its parent for that gradient. This builds one spanning tree per gradient by reverse path forwarding, and the flood stops by itself. The node sends that first copy once on each of its other links. It drops every later copy.

There are five gradients: four compass gradients and one cell gradient that leads toward the cell's connection to the coarse wiring. The cell gradient also carries the identifier of the cell whose root started it. Two neighbouring roots can both claim a node with different cell identifiers. Such a node marks itself as lying on a cell boundary and stops forwarding. A gradient the node never receives leaves no parent, so later traffic that follows that gradient is never steered into this node.

Received packets are parallel words with a valid/acknowledge pair on each link. Forwarded copies leave on one link at a time, and each copy is held until that link signals ready.

Top module: `grad_flood_node`

## Requirements
- R1: After the asynchronous reset, every gradient valid bit is 0, the boundary flag is 0, the recorded cell identifier is 0 and no link is driven for transmit.
- R2: The first accepted packet of a known gradient sets that gradient's valid bit and records the arrival link index (0 to 3) as its 2-bit parent pointer, at `par_link[2*g+1:2*g]`.
- R3: After a first copy, the node sends the packet, with gradient and cell identifier unchanged, on every link except the parent, in ascending link index. Each copy stays asserted on its link until that link's ready is high.
- R4: A later packet of an already-recorded gradient is acknowledged and dropped: nothing is sent, and the parent pointer and valid bit do not change.
- R5: Gradient identifiers are 3 bits: 0 north, 1 south, 2 east, 3 west, 4 cell. Identifiers 5 to 7 are acknowledged and dropped with no effect on any output.
- R6: The first cell gradient (identifier 4) records its 8-bit cell identifier. A later cell gradient with a different cell identifier sets the boundary flag, and one with the same identifier does not. The flag stays set until cleared.
- R7: While the boundary flag is set, first copies are still recorded as parents but are not forwarded on any link.
- R8: While idle, the node acknowledges exactly the lowest-index link that presents a packet. While it is forwarding, it acknowledges no link.
- R9: When two links present the same new gradient in the same cycle, the lower link index becomes the parent, and the other copy is later dropped.
- R10: A one-cycle `cfg_clr` pulse clears every valid bit and the boundary flag and aborts any forwarding in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Node clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clr | input | 1 | Synchronous clear of the gradient table and forwarder |
| rx_vld | input | 4 | Per-link receive valid |
| rx_gid | input | 12 | Per-link gradient identifier, 3 bits per link |
| rx_cid | input | 32 | Per-link cell identifier, 8 bits per link |
| rx_ack | output | 4 | Per-link receive acknowledge, at most one high |
| tx_rdy | input | 4 | Per-link transmit ready |
| tx_vld | output | 4 | Per-link transmit valid, at most one high |
| tx_gid | output | 3 | Gradient identifier being sent |
| tx_cid | output | 8 | Cell identifier being sent |
| par_vld | output | 5 | Per-gradient parent-recorded flag |
| par_link | output | 10 | Per-gradient parent link index, 2 bits per gradient |
| cell_id | output | 8 | Recorded cell identifier |
| boundary | output | 1 | Node lies on a cell boundary |

## Verification
The assertions assume that a link keeps its receive packet stable until it is acknowledged. They also assume that `cfg_clr` is a clean pulse: while it is high, the hold-until-ready and persistence properties are switched off. The bench drives all receive inputs on the falling edge. It holds each packet until it has seen that link's acknowledge and only then releases it. It drives transmit ready from a pseudo-random sequence, so copies wait a varied number of cycles. In the abort test it holds ready low, so that no copy completes while `cfg_clr` acts.

// File: rtl/gnode_pkg.sv
package gnode_pkg;

  typedef enum logic {
    FW_IDLE = 1'b0,
    FW_SEND = 1'b1
  } fw_state_e;

endpackage

// File: rtl/gnode_arb.sv
module gnode_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          en,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] gidx,
  output logic          any
);

  logic [N-1:0] lower_busy;

  assign lower_busy[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign lower_busy[i] = lower_busy[i-1] | req[i-1];
  end

  for (genvar i = 0; i < N; i++) begin : g_grant
    assign grant[i] = en & req[i] & ~lower_busy[i];
  end

  always_comb begin
    gidx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) gidx = IW'(i);
    end
  end

  assign any = |grant;

endmodule

// File: rtl/gnode_table.sv
module gnode_table #(
  parameter int NUM_GRAD  = 5,
  parameter int NUM_LINKS = 4,
  parameter int GID_W     = 3,
  parameter int CID_W     = 8,
  localparam int LIDX_W   = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
  localparam int CELL_G   = NUM_GRAD - 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       upd,
  input  logic [GID_W-1:0]           upd_gid,
  input  logic [CID_W-1:0]           upd_cid,
  input  logic [LIDX_W-1:0]          upd_link,
  output logic                       fwd_go,
  output logic [NUM_GRAD-1:0]        par_vld,
  output logic [NUM_GRAD*LIDX_W-1:0] par_link,
  output logic [CID_W-1:0]           cell_id,
  output logic                       boundary
);

  logic [NUM_GRAD-1:0]        vld_q, vld_d;
  logic [NUM_GRAD*LIDX_W-1:0] lnk_q, lnk_d;
  logic [CID_W-1:0]           cid_q, cid_d;
  logic                       bnd_q, bnd_d;
  logic                       vld_en, lnk_en, cid_en, bnd_en;

  logic known, seen, is_cell, first, conflict;

  always_comb begin
    known = 1'b0;
    seen  = 1'b0;
    for (int g = 0; g < NUM_GRAD; g++) begin
      if (upd_gid == GID_W'(g)) begin
        known = 1'b1;
        seen  = vld_q[g];
      end
    end
  end

  assign is_cell  = (upd_gid == GID_W'(CELL_G));
  assign first    = upd & known & ~seen;
  assign conflict = upd & is_cell & vld_q[CELL_G] & (upd_cid != cid_q);
  assign fwd_go   = first & ~bnd_q;

  always_comb begin
    vld_d  = vld_q;
    lnk_d  = lnk_q;
    cid_d  = cid_q;
    bnd_d  = bnd_q;
    vld_en = 1'b0;
    lnk_en = 1'b0;
    cid_en = 1'b0;
    bnd_en = 1'b0;
    if (clr) begin
      vld_d  = '0;
      bnd_d  = 1'b0;
      vld_en = 1'b1;
      bnd_en = 1'b1;
    end else begin
      if (first) begin
        for (int g = 0; g < NUM_GRAD; g++) begin
          if (upd_gid == GID_W'(g)) begin
            vld_d[g] = 1'b1;
            lnk_d[g*LIDX_W +: LIDX_W] = upd_link;
          end
        end
        vld_en = 1'b1;
        lnk_en = 1'b1;
        if (is_cell) begin
          cid_d  = upd_cid;
          cid_en = 1'b1;
        end
      end
      if (conflict) begin
        bnd_d  = 1'b1;
        bnd_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      lnk_q <= '0;
      cid_q <= '0;
      bnd_q <= 1'b0;
    end else begin
      if (vld_en) vld_q <= vld_d;
      if (lnk_en) lnk_q <= lnk_d;
      if (cid_en) cid_q <= cid_d;
      if (bnd_en) bnd_q <= bnd_d;
    end
  end

  assign par_vld  = vld_q;
  assign par_link = lnk_q;
  assign cell_id  = cid_q;
  assign boundary = bnd_q;

  // R4
  for (genvar g = 0; g < NUM_GRAD; g++) begin : g_persist
    parent_keep_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
      vld_q[g] |=> vld_q[g] && $stable(lnk_q[g*LIDX_W +: LIDX_W]));
  end

  // R6
  boundary_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    bnd_q |=> bnd_q);

  // R6
  boundary_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bnd_q) |-> $past(upd) && $past(is_cell));

endmodule

// File: rtl/gnode_fwd.sv
module gnode_fwd #(
  parameter int NUM_LINKS = 4,
  parameter int GID_W     = 3,
  parameter int CID_W     = 8,
  localparam int LIDX_W   = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 start,
  input  logic [GID_W-1:0]     start_gid,
  input  logic [CID_W-1:0]     start_cid,
  input  logic [LIDX_W-1:0]    start_parent,
  input  logic [NUM_LINKS-1:0] tx_rdy,
  output logic [NUM_LINKS-1:0] tx_vld,
  output logic [GID_W-1:0]     tx_gid,
  output logic [CID_W-1:0]     tx_cid,
  output logic                 busy
);

  import gnode_pkg::*;

  fw_state_e          st_q, st_d;
  logic [LIDX_W-1:0]  cur_q, cur_d;
  logic [LIDX_W-1:0]  par_q, par_d;
  logic [GID_W-1:0]   gid_q, gid_d;
  logic [CID_W-1:0]   cid_q, cid_d;
  logic               st_en, ctx_en;

  logic [LIDX_W-1:0]  first_idx, step_idx;
  logic               has_first, has_step;

  always_comb begin
    first_idx = '0;
    has_first = 1'b0;
    for (int i = NUM_LINKS - 1; i >= 0; i--) begin
      if (LIDX_W'(i) != start_parent) begin
        first_idx = LIDX_W'(i);
        has_first = 1'b1;
      end
    end
  end

  always_comb begin
    step_idx = '0;
    has_step = 1'b0;
    for (int i = NUM_LINKS - 1; i >= 0; i--) begin
      if ((LIDX_W'(i) > cur_q) && (LIDX_W'(i) != par_q)) begin
        step_idx = LIDX_W'(i);
        has_step = 1'b1;
      end
    end
  end

  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    par_d  = par_q;
    gid_d  = gid_q;
    cid_d  = cid_q;
    st_en  = 1'b0;
    ctx_en = 1'b0;
    if (clr) begin
      st_d  = FW_IDLE;
      st_en = 1'b1;
    end else begin
      unique case (st_q)
        FW_IDLE: begin
          if (start && has_first) begin
            st_d   = FW_SEND;
            cur_d  = first_idx;
            par_d  = start_parent;
            gid_d  = start_gid;
            cid_d  = start_cid;
            st_en  = 1'b1;
            ctx_en = 1'b1;
          end
        end
        FW_SEND: begin
          if (tx_rdy[cur_q]) begin
            if (has_step) begin
              cur_d  = step_idx;
              ctx_en = 1'b1;
            end else begin
              st_d  = FW_IDLE;
              st_en = 1'b1;
            end
          end
        end
        default: begin
          st_d  = FW_IDLE;
          st_en = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FW_IDLE;
      cur_q <= '0;
      par_q <= '0;
      gid_q <= '0;
      cid_q <= '0;
    end else begin
      if (st_en) st_q <= st_d;
      if (ctx_en) begin
        cur_q <= cur_d;
        par_q <= par_d;
        gid_q <= gid_d;
        cid_q <= cid_d;
      end
    end
  end

  assign busy   = (st_q == FW_SEND);
  assign tx_vld = busy ? (NUM_LINKS'(1) << cur_q) : '0;
  assign tx_gid = gid_q;
  assign tx_cid = cid_q;

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    ((tx_vld != '0) && ((tx_vld & tx_rdy) == '0))
      |=> $stable(tx_vld) && $stable(tx_gid) && $stable(tx_cid));

  // R3
  tx_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    ((tx_vld != '0) && ((tx_vld & tx_rdy) != '0))
      |=> (tx_vld == '0) || (tx_vld > $past(tx_vld)));

endmodule

// File: rtl/grad_flood_node.sv
module grad_flood_node #(
  parameter int NUM_LINKS = 4,
  parameter int NUM_GRAD  = 5,
  parameter int GID_W     = 3,
  parameter int CID_W     = 8,
  localparam int LIDX_W   = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_clr,
  input  logic [NUM_LINKS-1:0]       rx_vld,
  input  logic [NUM_LINKS*GID_W-1:0] rx_gid,
  input  logic [NUM_LINKS*CID_W-1:0] rx_cid,
  output logic [NUM_LINKS-1:0]       rx_ack,
  input  logic [NUM_LINKS-1:0]       tx_rdy,
  output logic [NUM_LINKS-1:0]       tx_vld,
  output logic [GID_W-1:0]           tx_gid,
  output logic [CID_W-1:0]           tx_cid,
  output logic [NUM_GRAD-1:0]        par_vld,
  output logic [NUM_GRAD*LIDX_W-1:0] par_link,
  output logic [CID_W-1:0]           cell_id,
  output logic                       boundary
);

  logic              busy;
  logic              acc;
  logic [LIDX_W-1:0] acc_link;
  logic [GID_W-1:0]  acc_gid;
  logic [CID_W-1:0]  acc_cid;
  logic              fwd_go;

  gnode_arb #(.N(NUM_LINKS)) arb_i (
    .en    (~busy & ~cfg_clr),
    .req   (rx_vld),
    .grant (rx_ack),
    .gidx  (acc_link),
    .any   (acc)
  );

  assign acc_gid = rx_gid[acc_link*GID_W +: GID_W];
  assign acc_cid = rx_cid[acc_link*CID_W +: CID_W];

  gnode_table #(
    .NUM_GRAD  (NUM_GRAD),
    .NUM_LINKS (NUM_LINKS),
    .GID_W     (GID_W),
    .CID_W     (CID_W)
  ) table_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cfg_clr),
    .upd      (acc),
    .upd_gid  (acc_gid),
    .upd_cid  (acc_cid),
    .upd_link (acc_link),
    .fwd_go   (fwd_go),
    .par_vld  (par_vld),
    .par_link (par_link),
    .cell_id  (cell_id),
    .boundary (boundary)
  );

  gnode_fwd #(
    .NUM_LINKS (NUM_LINKS),
    .GID_W     (GID_W),
    .CID_W     (CID_W)
  ) fwd_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (cfg_clr),
    .start        (fwd_go),
    .start_gid    (acc_gid),
    .start_cid    (acc_cid),
    .start_parent (acc_link),
    .tx_rdy       (tx_rdy),
    .tx_vld       (tx_vld),
    .tx_gid       (tx_gid),
    .tx_cid       (tx_cid),
    .busy         (busy)
  );

  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_ack));

  // R8
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld != '0) |-> (rx_ack == '0));

  // R3
  tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_vld));

  // R3
  tx_not_parent_chk: assert property (@(posedge clk) disable iff (!rst_n || cfg_clr)
    (tx_vld != '0) |-> (tx_vld[par_link[tx_gid*LIDX_W +: LIDX_W]] == 1'b0));

  // R10
  clr_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clr |=> (tx_vld == '0) && (par_vld == '0) && !boundary);

endmodule

// File: tb/grad_flood_node_tb_top.sv
module grad_flood_node_tb_top;

  localparam int NL = 4;
  localparam int NG = 5;
  localparam int GW = 3;
  localparam int CW = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           cfg_clr;
  logic [NL-1:0]  rx_vld;
  logic [NL*GW-1:0] rx_gid;
  logic [NL*CW-1:0] rx_cid;
  logic [NL-1:0]  rx_ack;
  logic [NL-1:0]  tx_rdy;
  logic [NL-1:0]  tx_vld;
  logic [GW-1:0]  tx_gid;
  logic [CW-1:0]  tx_cid;
  logic [NG-1:0]  par_vld;
  logic [NG*2-1:0] par_link;
  logic [CW-1:0]  cell_id;
  logic           boundary;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit rdy_hold = 1'b0;
  logic [12:0] expq[$];
  logic [15:0] lfsr = 16'hACE1;

  always #10ns clk = ~clk;

  grad_flood_node dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_clr(cfg_clr),
    .rx_vld(rx_vld), .rx_gid(rx_gid), .rx_cid(rx_cid), .rx_ack(rx_ack),
    .tx_rdy(tx_rdy), .tx_vld(tx_vld), .tx_gid(tx_gid), .tx_cid(tx_cid),
    .par_vld(par_vld), .par_link(par_link), .cell_id(cell_id),
    .boundary(boundary)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // pseudo-random ready pattern
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_rdy = rdy_hold ? 4'b0000 : lfsr[3:0];
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #5ns;
      if ((tx_vld & tx_rdy) != 4'b0000) begin
        int lk;
        lk = 0;
        for (int k = 0; k < NL; k++) if (tx_vld[k]) lk = k;
        if (expq.size() == 0) begin
          check(1'b0, "R3/R4 unexpected send", {lk[1:0], tx_gid, tx_cid}, 0);
        end else begin
          logic [12:0] e, a;
          e = expq.pop_front();
          a = {lk[1:0], tx_gid, tx_cid};
          check(a == e, "R3 forwarded copy", a, e);
        end
      end
    end
  end

  task automatic push_fwd(input int g, input int c, input int parent);
    for (int k = 0; k < NL; k++)
      if (k != parent) expq.push_back({k[1:0], g[2:0], c[7:0]});
  endtask

  task automatic set_link(input int k, input int g, input int c);
    rx_gid[k*GW +: GW] = g[GW-1:0];
    rx_cid[k*CW +: CW] = c[CW-1:0];
  endtask

  task automatic present(input logic [NL-1:0] mask);
    logic [NL-1:0] pend, acked;
    @(negedge clk);
    pend = mask;
    rx_vld = pend;
    while (pend != 0) begin
      #1ns;
      acked = rx_ack & pend;
      @(posedge clk);
      @(negedge clk);
      pend = pend & ~acked;
      rx_vld = pend;
    end
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (expq.size() != 0 || tx_vld != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic int plink(input int g);
    return int'(par_link[g*2 +: 2]);
  endfunction

  task automatic pulse_clr();
    @(negedge clk);
    cfg_clr = 1'b1;
    @(negedge clk);
    cfg_clr = 1'b0;
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_clr = 1'b0;
    rx_vld = '0;
    rx_gid = '0;
    rx_cid = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(par_vld == 0, "R1 par_vld", par_vld, 0);
    check(boundary == 0, "R1 boundary", boundary, 0);
    check(cell_id == 0, "R1 cell_id", cell_id, 0);
    check(tx_vld == 0, "R1 tx_vld", tx_vld, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 first copy of gradient 0 on link 2
    set_link(2, 0, 'h11);
    push_fwd(0, 'h11, 2);
    present(4'b0100);
    wait_idle();
    check(par_vld[0] == 1'b1, "R2 valid g0", par_vld[0], 1);
    check(plink(0) == 2, "R2 parent g0", plink(0), 2);

    // R4 duplicate on link 1
    set_link(1, 0, 'h99);
    present(4'b0010);
    wait_idle();
    check(plink(0) == 2, "R4 parent kept", plink(0), 2);
    check(par_vld == 5'b00001, "R4 valid set", par_vld, 5'b00001);

    // R6 cell gradient first copy on link 0
    set_link(0, 4, 'h5A);
    push_fwd(4, 'h5A, 0);
    present(4'b0001);
    wait_idle();
    check(cell_id == 8'h5A, "R6 cell id", cell_id, 'h5A);
    check(plink(4) == 0, "R2 parent cell", plink(4), 0);

    // R6 same cell id again: no boundary
    set_link(3, 4, 'h5A);
    present(4'b1000);
    wait_idle();
    check(boundary == 1'b0, "R6 same id", boundary, 0);

    // R5 unknown id 6
    set_link(1, 6, 'h33);
    present(4'b0010);
    wait_idle();
    check(par_vld == 5'b10001, "R5 unknown id", par_vld, 5'b10001);
    check(boundary == 1'b0, "R5 boundary", boundary, 0);

    // R9 same gradient on links 1 and 3 together
    set_link(1, 2, 'h42);
    set_link(3, 2, 'h43);
    push_fwd(2, 'h42, 1);
    present(4'b1010);
    wait_idle();
    check(plink(2) == 1, "R9 lower link wins", plink(2), 1);

    // R6 conflicting cell id sets boundary
    set_link(2, 4, 'h77);
    present(4'b0100);
    wait_idle();
    check(boundary == 1'b1, "R6 conflict", boundary, 1);
    check(cell_id == 8'h5A, "R6 id kept", cell_id, 'h5A);

    // R7 boundary node records but does not forward
    set_link(0, 3, 'h10);
    present(4'b0001);
    wait_idle();
    check(par_vld[3] == 1'b1, "R7 recorded", par_vld[3], 1);
    check(plink(3) == 0, "R7 parent", plink(3), 0);

    // R10 clear
    pulse_clr();
    @(negedge clk);
    check(par_vld == 0, "R10 valid cleared", par_vld, 0);
    check(boundary == 1'b0, "R10 boundary cleared", boundary, 0);

    // R8 arbitration: link 0 first, link 3 held while busy
    set_link(0, 1, 'h21);
    set_link(3, 2, 'h32);
    push_fwd(1, 'h21, 0);
    push_fwd(2, 'h32, 3);
    @(negedge clk);
    rx_vld = 4'b1001;
    #1ns;
    check(rx_ack == 4'b0001, "R8 lowest acked", rx_ack, 4'b0001);
    @(posedge clk);
    @(negedge clk);
    rx_vld = 4'b1000;
    #1ns;
    check(tx_vld != 0, "R8 busy", tx_vld, 1);
    check(rx_ack == 4'b0000, "R8 no ack while busy", rx_ack, 0);
    begin
      logic got;
      got = 1'b0;
      while (!got) begin
        #1ns;
        got = rx_ack[3];
        @(posedge clk);
        @(negedge clk);
      end
      rx_vld = 4'b0000;
    end
    wait_idle();
    check(plink(1) == 0 && plink(2) == 3, "R8 parents", {plink(1), plink(2)}, 3);

    // R10 abort forwarding in progress
    pulse_clr();
    rdy_hold = 1'b1;
    set_link(1, 0, 'h66);
    present(4'b0010);
    repeat (3) @(negedge clk);
    check(tx_vld == 4'b0001, "R3 held without ready", tx_vld, 4'b0001);
    pulse_clr();
    #1ns;
    check(tx_vld == 4'b0000, "R10 abort", tx_vld, 0);
    check(par_vld == 0, "R10 table cleared", par_vld, 0);
    rdy_hold = 1'b0;
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R3 all copies seen", expq.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule